// File: doc/BRIEF.md
# Upset-Tolerant Power Sequencing Controller

This block sequences the power-up of a mixed-signal converter and keeps that sequence correct when a single logic upset hits its decision logic. Three identical copies of the next-state and output logic each read one shared state register and each propose a next state and a set of control outputs. A bitwise two-of-three majority voter settles each state bit and each output bit before it is stored, so a single corrupted copy has no effect on the stored result.

The sequence runs from idle, to a phase that requests configuration and waits for it, to a phase with only the digital path enabled, and finally to a phase with both the digital and the analog paths enabled. A digital power-down request sends the controller back to idle from anywhere. An analog power-down request holds or returns it to the digital-only phase. A test port XORs chosen bit masks into the candidates of any chosen copies, and a mismatch flag reports that the copies disagreed.

Top module: `tmr_pwr_seq`

## Requirements
- R1: Reset is synchronous and active low: on a clock edge with `rst_n` low, `state` becomes idle (3'b000) and `cfg_req`, `dig_en`, `ana_en` and `mismatch` become 0.
- R2: From idle (3'b000), with `pd_dig` low, the next state is the configuration wait (3'b001).
- R3: The configuration wait (3'b001) holds while `cfg_done` is low and moves to digital-on (3'b011) on the edge where `cfg_done` is high.
- R4: Digital-on (3'b011) moves to run (3'b111) on an edge where `pd_ana` is low; run holds while `pd_ana` stays low.
- R5: With `pd_ana` high, both run (3'b111) and digital-on (3'b011) go to digital-on.
- R6: `pd_dig` high sends every state to idle (3'b000) on the next edge and takes priority over `cfg_done` and `pd_ana`.
- R7: The outputs are registered with the state they belong to: `cfg_req` is 1 only in 3'b001, `dig_en` is 1 only in 3'b011 and 3'b111, `ana_en` is 1 only in 3'b111.
- R8: With exactly one bit of `inj_sel` set, any `inj_state_mask` and `inj_out_mask` leave `state` and the three outputs equal to the fault-free values.
- R9: `mismatch` is 1 for the cycle after an edge where one or two copies are selected by `inj_sel` (bit i selects copy i) with a nonzero mask, and 0 after any other edge.
- R10: When two or three copies are selected, their masked values win the vote; a resulting unused state (3'b010, 3'b100, 3'b101, 3'b110) goes to idle on the next edge regardless of `pd_dig`, with all three outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_done | input | 1 | Configuration has been loaded |
| pd_dig | input | 1 | Digital power-down request |
| pd_ana | input | 1 | Analog power-down request |
| inj_sel | input | 3 | Test: one bit per copy selecting which copies are corrupted |
| inj_state_mask | input | 3 | Test: XOR mask on the selected copies' next-state candidate |
| inj_out_mask | input | 3 | Test: XOR mask on the selected copies' output candidates (bit0 cfg_req, bit1 dig_en, bit2 ana_en) |
| state | output | 3 | Voted, registered state |
| cfg_req | output | 1 | Configuration requested |
| dig_en | output | 1 | Digital path enable |
| ana_en | output | 1 | Analog path enable |
| mismatch | output | 1 | The copies disagreed on the last edge |

## Verification
The full power-up walk is driven with `cfg_done` held off for several cycles, then analog requests toggled in both the digital-only and run phases, which separates correct hold behaviour from premature advance. Digital power-down is applied together with `cfg_done` and `pd_ana` to show its priority, and reset is asserted mid-run. Single-copy faults with varied masks on each copy in turn show that voting masks the corruption while the flag still rises, and two-copy faults that produce an unused encoding show the majority override and the one-edge recovery to idle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int STATE_W = 3;
    localparam int OUT_W   = 3;
    localparam int N_COPY  = 3;

    localparam logic [STATE_W-1:0] ST_IDLE = 3'b000;
    localparam logic [STATE_W-1:0] ST_WCFG = 3'b001;
    localparam logic [STATE_W-1:0] ST_DIG  = 3'b011;
    localparam logic [STATE_W-1:0] ST_RUN  = 3'b111;

    localparam int O_CFG = 0;
    localparam int O_DIG = 1;
    localparam int O_ANA = 2;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic [OUT_W-1:0]   outs;
        logic               mism;
    } seq_reg_t;
endpackage

// File: rtl/tmr_vote.sv
module tmr_vote #(
    parameter int W = 3
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] y,
    output logic         differ
);
    always_comb begin
        y      = (a & b) | (a & c) | (b & c);
        differ = (a != y) || (b != y) || (c != y);
    end
endmodule

// File: rtl/tmr_seq_copy.sv
module tmr_seq_copy
    import tmr_pkg::*;
(
    input  logic [STATE_W-1:0] cur,
    input  logic               cfg_done,
    input  logic               pd_dig,
    input  logic               pd_ana,
    input  logic [STATE_W-1:0] st_flip,
    input  logic [OUT_W-1:0]   out_flip,
    output logic [STATE_W-1:0] nxt,
    output logic [OUT_W-1:0]   outs
);
    logic [STATE_W-1:0] clean;
    logic [OUT_W-1:0]   clean_out;

    always_comb begin
        case (cur)
            ST_IDLE: clean = ST_WCFG;
            ST_WCFG: clean = cfg_done ? ST_DIG : ST_WCFG;
            ST_DIG:  clean = pd_ana ? ST_DIG : ST_RUN;
            ST_RUN:  clean = pd_ana ? ST_DIG : ST_RUN;
            default: clean = ST_IDLE;
        endcase
        if (pd_dig) begin
            clean = ST_IDLE;
        end

        clean_out        = '0;
        clean_out[O_CFG] = (clean == ST_WCFG);
        clean_out[O_DIG] = (clean == ST_DIG) || (clean == ST_RUN);
        clean_out[O_ANA] = (clean == ST_RUN);

        nxt  = clean ^ st_flip;
        outs = clean_out ^ out_flip;
    end
endmodule

// File: rtl/tmr_pwr_seq.sv
module tmr_pwr_seq
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_done,
    input  logic               pd_dig,
    input  logic               pd_ana,
    input  logic [N_COPY-1:0]  inj_sel,
    input  logic [STATE_W-1:0] inj_state_mask,
    input  logic [OUT_W-1:0]   inj_out_mask,
    output logic [STATE_W-1:0] state,
    output logic               cfg_req,
    output logic               dig_en,
    output logic               ana_en,
    output logic               mismatch
);
    seq_reg_t r_d, r_q;

    logic [STATE_W-1:0] cand_st  [N_COPY];
    logic [OUT_W-1:0]   cand_out [N_COPY];
    logic [STATE_W-1:0] voted_st;
    logic [OUT_W-1:0]   voted_out;
    logic               st_differ;
    logic               out_differ;

    for (genvar g = 0; g < N_COPY; g++) begin : g_copy
        tmr_seq_copy u_copy (
            .cur      (r_q.state),
            .cfg_done (cfg_done),
            .pd_dig   (pd_dig),
            .pd_ana   (pd_ana),
            .st_flip  (inj_sel[g] ? inj_state_mask : '0),
            .out_flip (inj_sel[g] ? inj_out_mask : '0),
            .nxt      (cand_st[g]),
            .outs     (cand_out[g])
        );
    end

    tmr_vote #(.W(STATE_W)) u_vote_st (
        .a      (cand_st[0]),
        .b      (cand_st[1]),
        .c      (cand_st[2]),
        .y      (voted_st),
        .differ (st_differ)
    );

    tmr_vote #(.W(OUT_W)) u_vote_out (
        .a      (cand_out[0]),
        .b      (cand_out[1]),
        .c      (cand_out[2]),
        .y      (voted_out),
        .differ (out_differ)
    );

    always_comb begin
        r_d       = r_q;
        r_d.state = voted_st;
        r_d.outs  = voted_out;
        r_d.mism  = st_differ || out_differ;
        if (!rst_n) begin
            r_d.state = ST_IDLE;
            r_d.outs  = '0;
            r_d.mism  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state    = r_q.state;
    assign cfg_req  = r_q.outs[O_CFG];
    assign dig_en   = r_q.outs[O_DIG];
    assign ana_en   = r_q.outs[O_ANA];
    assign mismatch = r_q.mism;
endmodule

// File: rtl/tmr_pwr_seq_chk.sv
module tmr_pwr_seq_chk
    import tmr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_done,
    input logic               pd_dig,
    input logic               pd_ana,
    input logic [N_COPY-1:0]  inj_sel,
    input logic [STATE_W-1:0] state,
    input logic               cfg_req,
    input logic               dig_en,
    input logic               ana_en,
    input logic               mismatch
);
    logic legal;
    assign legal = (state == ST_IDLE) || (state == ST_WCFG) ||
                   (state == ST_DIG)  || (state == ST_RUN);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (state == ST_IDLE && !mismatch && !cfg_req && !dig_en && !ana_en));

    assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WCFG && !cfg_done && !pd_dig && inj_sel == '0) |=> state == ST_WCFG);

    assert_pd_dig_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_dig && inj_sel == '0) |=> state == ST_IDLE);

    assert_out_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_sel == '0) |=> (cfg_req == (state == ST_WCFG) &&
                             dig_en == (state == ST_DIG || state == ST_RUN) &&
                             ana_en == (state == ST_RUN)));

    assert_single_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(inj_sel) <= 1) |=> legal);

    assert_quiet_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_sel == '0) |=> !mismatch);

    assert_unused_recover_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!legal && inj_sel == '0) |=> state == ST_IDLE);
endmodule

bind tmr_pwr_seq tmr_pwr_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_done (cfg_done),
    .pd_dig   (pd_dig),
    .pd_ana   (pd_ana),
    .inj_sel  (inj_sel),
    .state    (state),
    .cfg_req  (cfg_req),
    .dig_en   (dig_en),
    .ana_en   (ana_en),
    .mismatch (mismatch)
);

// File: tb/tmr_pwr_seq_tb.sv
`timescale 1ns/1ps
module tmr_pwr_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_done = 1'b0;
    logic       pd_dig = 1'b0;
    logic       pd_ana = 1'b0;
    logic [2:0] inj_sel = 3'b000;
    logic [2:0] inj_state_mask = 3'b000;
    logic [2:0] inj_out_mask = 3'b000;
    logic [2:0] state;
    logic       cfg_req, dig_en, ana_en, mismatch;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int         m_state = 0;
    logic [2:0] m_out = 3'b000;
    logic       m_mism = 1'b0;

    always #2.5 clk = ~clk;

    tmr_pwr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .pd_dig(pd_dig),
        .pd_ana(pd_ana), .inj_sel(inj_sel), .inj_state_mask(inj_state_mask),
        .inj_out_mask(inj_out_mask), .state(state), .cfg_req(cfg_req),
        .dig_en(dig_en), .ana_en(ana_en), .mismatch(mismatch)
    );

    function automatic int ref_next(int cur);
        if (pd_dig) return 0;
        if (cur == 0) return 1;
        if (cur == 1) return cfg_done ? 3 : 1;
        if (cur == 3 || cur == 7) return pd_ana ? 3 : 7;
        return 0;
    endfunction

    task automatic model_edge();
        int nxt;
        int n;
        logic [2:0] o;
        if (!rst_n) begin
            m_state = 0; m_out = 3'b000; m_mism = 1'b0;
            return;
        end
        nxt = ref_next(m_state);
        o = {nxt == 7, (nxt == 3 || nxt == 7), nxt == 1};
        n = $countones(inj_sel);
        if (n >= 2) begin
            nxt = nxt ^ int'(inj_state_mask);
            o   = o ^ inj_out_mask;
        end
        m_mism  = (n == 1 || n == 2) && (inj_state_mask != 0 || inj_out_mask != 0);
        m_state = nxt;
        m_out   = o;
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "state", int'(state), m_state);
        chk("R7", "outputs", int'({ana_en, dig_en, cfg_req}), int'(m_out));
        chk("R9", "mismatch", int'(mismatch), int'(m_mism));
    endtask

    task automatic inject(logic [2:0] sel, logic [2:0] sm, logic [2:0] om);
        inj_sel = sel; inj_state_mask = sm; inj_out_mask = om;
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step("R1"); step("R1");
        rst_n = 1'b1; pd_dig = 1'b1;
        step("R6"); step("R6");
        pd_dig = 1'b0;
        step("R2");
        repeat (3) step("R3");
        cfg_done = 1'b1; step("R3");
        cfg_done = 1'b0; pd_ana = 1'b1;
        step("R5"); step("R5");
        pd_ana = 1'b0; step("R4"); step("R4");
        pd_ana = 1'b1; step("R5");
        pd_ana = 1'b0; step("R4");
        pd_dig = 1'b1; pd_ana = 1'b1; cfg_done = 1'b1; step("R6");
        pd_ana = 1'b0; cfg_done = 1'b0; step("R6");
        pd_dig = 1'b0; step("R2");
        pd_dig = 1'b1; step("R6");
        pd_dig = 1'b0; step("R2");
        cfg_done = 1'b1; step("R3");
        pd_dig = 1'b1; step("R6");
        pd_dig = 1'b0; cfg_done = 1'b0; step("R2");
        // single-copy faults on each copy in turn
        for (int i = 0; i < 3; i++) begin
            inject(3'b001 << i, 3'b111, 3'b000); step("R8");
            inject(3'b001 << i, 3'b000, 3'b101); step("R8");
            inject(3'b000, 3'b000, 3'b000); step("R8");
        end
        cfg_done = 1'b1;
        inject(3'b010, 3'b110, 3'b011); step("R8");
        cfg_done = 1'b0;
        inject(3'b100, 3'b100, 3'b100); step("R8");
        inject(3'b001, 3'b000, 3'b000); step("R9");
        inject(3'b000, 3'b000, 3'b000); step("R4");
        // reset in the middle of run
        rst_n = 1'b0; step("R1");
        rst_n = 1'b1; pd_dig = 1'b1; step("R6");
        // two-copy faults to an unused encoding, then recovery
        inject(3'b011, 3'b101, 3'b000); step("R10");
        inject(3'b000, 3'b000, 3'b000); pd_dig = 1'b0; step("R10");
        step("R2");
        inject(3'b110, 3'b111, 3'b010); step("R10");
        inject(3'b000, 3'b000, 3'b000); step("R10");
        inject(3'b111, 3'b011, 3'b000); step("R10");
        inject(3'b000, 3'b000, 3'b000); step("R10");
        step("R2");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule